// File: doc/BRIEF.md
# Stack Machine Top-of-Stack Datapath

This block is the data-side core of a small 16-bit stack processor. The top of the data stack is held in a register (T). The entries below it live in a 256-entry synchronous RAM, whose top entry (S) is presented as a registered read port. One decoded operation arrives on every clock. Each operation sets a new T from one of these sources:

- an ALU that combines T and S,
- an immediate literal,
- the memory read bus (the full word or a single byte lane),
- a shifted copy of T,
- a read multiplexer over special registers.

In the same cycle the operation pushes, pops or leaves the stack depth alone.

The stack does not manage its own limits, so the block detects both of them. A push on a full stack sets a sticky overflow flag. An operation that needs S on an empty stack sets a sticky underflow flag. Either fault suppresses the whole operation, so T, the depth and memory are left untouched. The carry flag, the overflow flag and the underflow flag together form a small control/status word that can be read back into T.

Instruction fetch, the program counter, the return stack and memory addressing are handled elsewhere. The block only sees the memory read data and drives a write strobe with write data.

Top module: `stk_tos_core`

## Requirements
- R1: After reset, T reads 0, the depth is 0, and the carry, overflow and underflow flags are 0.
- R2: Push operations LIT (op 1, T takes imm_i), DUP (op 2, T unchanged) and RDSR (op 15) move the old T into S and raise the depth by one.
- R3: A push operation (LIT, DUP, OVER, RDSR) at depth 256 sets the sticky overflow flag. It leaves T, S and the depth unchanged.
- R4: An operation needing S (OVER, DROP, NOT excluded, XOR, AND, ADD, ADDC, STW) at depth 0 sets the sticky underflow flag. It leaves T and the depth unchanged and gives no memory write.
- R5: XOR (op 6), AND (op 7) and ADD (op 8) load T with T combined with S. They lower the depth by one, and the next entry down becomes S.
- R6: ADD and ADDC (op 9) set the carry flag to the carry out of the 16-bit sum. ADDC also adds the current carry flag into the sum.
- R7: SHL (op 10) and SHR (op 11) shift T by one with zero fill and load the carry flag with the bit shifted out. The depth is unchanged.
- R8: NOT (op 5) inverts every bit of T and leaves the depth and S unchanged.
- R9: OVER (op 3) sets T to S and pushes the old T. DROP (op 4) sets T to S and pops.
- R10: LDW (op 12) loads T with mem_rdata_i. LDL (op 13) loads mem_rdata_i[7:0] and LDH (op 14) loads mem_rdata_i[15:8], both zero-extended. The depth is unchanged.
- R11: RDSR selects its value with imm_i[2:0]:
  - 0 gives the status word {unf, ovf, carry} in bits [2:0].
  - 1 gives page_a_i and 2 gives page_r_i.
  - 3 gives the depth before the operation, zero-extended.
  - 4 gives rsp_i.
  - Any other select gives 0.
- R12: STW (op 16) drives mem_we_o high and mem_wdata_o equal to T in the same cycle. At the clock edge T takes S and the depth drops by one.
- R13: NOP (op 0) and opcodes 17 to 31 change neither T, S, the depth nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Decoded operation for this cycle |
| imm_i | input | 16 | Literal value, or special-register select in bits [2:0] |
| mem_rdata_i | input | 16 | Memory read data for load operations |
| page_a_i | input | 16 | Address page register A, readable through RDSR |
| page_r_i | input | 16 | Address page register R, readable through RDSR |
| rsp_i | input | 16 | Return stack pointer, readable through RDSR |
| tos_o | output | 16 | Current T |
| nos_o | output | 16 | Current S (meaningful when depth is above 0) |
| depth_o | output | 9 | Number of entries below T, 0 to 256 |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| mem_we_o | output | 1 | Memory write strobe, combinational from op_i |
| mem_wdata_o | output | 16 | Memory write data (T) |

## Verification
T, S, the depth and all three flags are registered. An operation presented before a rising edge is therefore reflected on those outputs right after that edge, with no further latency. The store strobe and its data are combinational, so they are due in the same cycle as the STW operation, before the edge. The bench drives each operation at a falling edge and samples the write strobe 1 ns later. It then samples the registered outputs at the following falling edge, half a period after the updating edge. Each sample is compared with a software model of T, the stack contents, the depth and the flags.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [4:0] {
      OP_NOP  = 5'd0,
      OP_LIT  = 5'd1,
      OP_DUP  = 5'd2,
      OP_OVER = 5'd3,
      OP_DROP = 5'd4,
      OP_NOT  = 5'd5,
      OP_XOR  = 5'd6,
      OP_AND  = 5'd7,
      OP_ADD  = 5'd8,
      OP_ADDC = 5'd9,
      OP_SHL  = 5'd10,
      OP_SHR  = 5'd11,
      OP_LDW  = 5'd12,
      OP_LDL  = 5'd13,
      OP_LDH  = 5'd14,
      OP_RDSR = 5'd15,
      OP_STW  = 5'd16
   } op_e;

   typedef enum logic [1:0] {
      EFF_NONE = 2'd0,
      EFF_PUSH = 2'd1,
      EFF_POP  = 2'd2
   } eff_e;

   // status word bit positions
   localparam int CSR_CARRY = 0;
   localparam int CSR_OVF   = 1;
   localparam int CSR_UNF   = 2;

   // special register selects
   localparam logic [2:0] SR_CSR = 3'd0;
   localparam logic [2:0] SR_PGA = 3'd1;
   localparam logic [2:0] SR_PGR = 3'd2;
   localparam logic [2:0] SR_DSP = 3'd3;
   localparam logic [2:0] SR_RSP = 3'd4;

   function automatic eff_e op_effect(logic [4:0] op);
      case (op)
         OP_LIT, OP_DUP, OP_OVER, OP_RDSR:                       return EFF_PUSH;
         OP_DROP, OP_XOR, OP_AND, OP_ADD, OP_ADDC, OP_STW:       return EFF_POP;
         default:                                                return EFF_NONE;
      endcase
   endfunction

   function automatic logic op_needs_s(logic [4:0] op);
      return (op_effect(op) == EFF_POP) || (op == OP_OVER);
   endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
   import stk_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] t,
   input  logic [W-1:0] s,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout,
   output logic         cwe
);

   logic [W:0] sum;
   logic       add_cin;

   always_comb begin
      add_cin = (op == OP_ADDC) && cin;
      sum     = {1'b0, t} + {1'b0, s} + {{W{1'b0}}, add_cin};
   end

   always_comb begin
      res  = t;
      cout = cin;
      cwe  = 1'b0;
      case (op)
         OP_NOT: res = ~t;
         OP_XOR: res = t ^ s;
         OP_AND: res = t & s;
         OP_ADD, OP_ADDC: begin
            res  = sum[W-1:0];
            cout = sum[W];
            cwe  = 1'b1;
         end
         OP_SHL: begin
            res  = {t[W-2:0], 1'b0};
            cout = t[W-1];
            cwe  = 1'b1;
         end
         OP_SHR: begin
            res  = {1'b0, t[W-1:1]};
            cout = t[0];
            cwe  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/stk_tmux.sv
module stk_tmux
   import stk_pkg::*;
#(
   parameter int W  = 16,
   parameter int DW = 9
) (
   input  logic [4:0]    op,
   input  logic [W-1:0]  t,
   input  logic [W-1:0]  s,
   input  logic [W-1:0]  imm,
   input  logic [W-1:0]  alu_res,
   input  logic [W-1:0]  mem_rdata,
   input  logic [W-1:0]  page_a,
   input  logic [W-1:0]  page_r,
   input  logic [W-1:0]  rsp,
   input  logic [DW-1:0] depth,
   input  logic          carry,
   input  logic          ovf,
   input  logic          unf,
   output logic [W-1:0]  t_nxt
);

   localparam int LANES = W / 8;

   logic [7:0]   lane [LANES];
   logic [W-1:0] csr_word;
   logic [W-1:0] sr_val;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = mem_rdata[g*8 +: 8];
   end

   always_comb begin
      csr_word            = '0;
      csr_word[CSR_CARRY] = carry;
      csr_word[CSR_OVF]   = ovf;
      csr_word[CSR_UNF]   = unf;
   end

   always_comb begin
      case (imm[2:0])
         SR_CSR:  sr_val = csr_word;
         SR_PGA:  sr_val = page_a;
         SR_PGR:  sr_val = page_r;
         SR_DSP:  sr_val = W'(depth);
         SR_RSP:  sr_val = rsp;
         default: sr_val = '0;
      endcase
   end

   always_comb begin
      case (op)
         OP_LIT:                  t_nxt = imm;
         OP_OVER, OP_DROP,
         OP_STW:                  t_nxt = s;
         OP_NOT, OP_XOR, OP_AND,
         OP_ADD, OP_ADDC,
         OP_SHL, OP_SHR:          t_nxt = alu_res;
         OP_LDW:                  t_nxt = mem_rdata;
         OP_LDL:                  t_nxt = W'(lane[0]);
         OP_LDH:                  t_nxt = W'(lane[1]);
         OP_RDSR:                 t_nxt = sr_val;
         default:                 t_nxt = t;
      endcase
   end

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
   parameter int W     = 16,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  q
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // registered read with write-first forwarding on an address match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= '0;
      else if (we && (waddr == raddr)) q <= wdata;
      else                             q <= mem[raddr];
   end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [4:0]    op,
   input  logic          carry_we,
   input  logic          carry_nxt,
   output logic [DW-1:0] depth,
   output logic          exec,
   output logic          push_wr,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic          carry,
   output logic          ovf,
   output logic          unf
);

   localparam logic [DW-1:0] FULL = DW'(DEPTH);

   eff_e          eff;
   logic          need_s;
   logic          f_over;
   logic          f_under;
   logic [DW-1:0] depth_nxt;
   logic [DW-1:0] dn_m1;

   always_comb begin
      eff     = op_effect(op);
      need_s  = op_needs_s(op);
      f_under = need_s && (depth == '0);
      f_over  = !f_under && (eff == EFF_PUSH) && (depth == FULL);
      exec    = !(f_under || f_over);
      push_wr = exec && (eff == EFF_PUSH);
      waddr   = depth[AW-1:0];
   end

   always_comb begin
      depth_nxt = depth;
      if (exec) begin
         case (eff)
            EFF_PUSH: depth_nxt = depth + 1'b1;
            EFF_POP:  depth_nxt = depth - 1'b1;
            default:  depth_nxt = depth;
         endcase
      end
      dn_m1 = depth_nxt - 1'b1;
      raddr = dn_m1[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth <= '0;
         carry <= 1'b0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else begin
         depth <= depth_nxt;
         if (exec && carry_we) carry <= carry_nxt;
         if (f_over)           ovf   <= 1'b1;
         if (f_under)          unf   <= 1'b1;
      end
   end

endmodule

// File: rtl/stk_tos_core.sv
module stk_tos_core
   import stk_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [4:0]    op_i,
   input  logic [W-1:0]  imm_i,
   input  logic [W-1:0]  mem_rdata_i,
   input  logic [W-1:0]  page_a_i,
   input  logic [W-1:0]  page_r_i,
   input  logic [W-1:0]  rsp_i,
   output logic [W-1:0]  tos_o,
   output logic [W-1:0]  nos_o,
   output logic [DW-1:0] depth_o,
   output logic          carry_o,
   output logic          ovf_o,
   output logic          unf_o,
   output logic          mem_we_o,
   output logic [W-1:0]  mem_wdata_o
);

   initial begin
      assert (W >= 16 && (W % 8) == 0)
         else $error("stk_tos_core: W must be a multiple of 8 and at least 16");
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("stk_tos_core: DEPTH must be a power of two");
      assert (DW <= W)
         else $error("stk_tos_core: depth must fit in a data word");
   end

   logic [W-1:0]  t_q;
   logic [W-1:0]  t_nxt;
   logic [W-1:0]  s_q;
   logic [W-1:0]  alu_res;
   logic          alu_cout;
   logic          alu_cwe;
   logic          exec;
   logic          push_wr;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic [DW-1:0] depth;
   logic          carry;
   logic          ovf;
   logic          unf;

   stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op_i),
      .carry_we  (alu_cwe),
      .carry_nxt (alu_cout),
      .depth     (depth),
      .exec      (exec),
      .push_wr   (push_wr),
      .waddr     (waddr),
      .raddr     (raddr),
      .carry     (carry),
      .ovf       (ovf),
      .unf       (unf)
   );

   stk_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (push_wr),
      .waddr (waddr),
      .wdata (t_q),
      .raddr (raddr),
      .q     (s_q)
   );

   stk_alu #(.W(W)) u_alu (
      .op   (op_i),
      .t    (t_q),
      .s    (s_q),
      .cin  (carry),
      .res  (alu_res),
      .cout (alu_cout),
      .cwe  (alu_cwe)
   );

   stk_tmux #(.W(W), .DW(DW)) u_tmux (
      .op        (op_i),
      .t         (t_q),
      .s         (s_q),
      .imm       (imm_i),
      .alu_res   (alu_res),
      .mem_rdata (mem_rdata_i),
      .page_a    (page_a_i),
      .page_r    (page_r_i),
      .rsp       (rsp_i),
      .depth     (depth),
      .carry     (carry),
      .ovf       (ovf),
      .unf       (unf),
      .t_nxt     (t_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    t_q <= '0;
      else if (exec) t_q <= t_nxt;
   end

   assign tos_o       = t_q;
   assign nos_o       = s_q;
   assign depth_o     = depth;
   assign carry_o     = carry;
   assign ovf_o       = ovf;
   assign unf_o       = unf;
   assign mem_we_o    = exec && (op_i == OP_STW);
   assign mem_wdata_o = t_q;

endmodule

// File: rtl/stk_tos_core_chk.sv
module stk_tos_core_chk
   import stk_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = AW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [4:0]    op_i,
   input logic [W-1:0]  tos_o,
   input logic [W-1:0]  nos_o,
   input logic [DW-1:0] depth_o,
   input logic          carry_o,
   input logic          ovf_o,
   input logic          unf_o,
   input logic          mem_we_o
);

   localparam logic [DW-1:0] FULL = DW'(DEPTH);

   p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      depth_o <= FULL);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_effect(op_i) == EFF_PUSH && depth_o == FULL)
      |=> (ovf_o && $stable(depth_o) && $stable(tos_o)));

   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_needs_s(op_i) && depth_o == '0)
      |=> (unf_o && $stable(depth_o) && $stable(tos_o)));

   p_unf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> unf_o);

   p_no_store_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_STW && depth_o == '0) |-> !mem_we_o);

   p_dup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_DUP && depth_o != FULL)
      |=> (tos_o == $past(tos_o) && nos_o == $past(tos_o)
           && depth_o == $past(depth_o) + 1'b1));

   p_binop_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == OP_XOR || op_i == OP_AND || op_i == OP_ADD) && depth_o != '0)
      |=> (depth_o == $past(depth_o) - 1'b1));

   p_shl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SHL)
      |=> (tos_o == {$past(tos_o[W-2:0]), 1'b0} && carry_o == $past(tos_o[W-1])
           && $stable(depth_o)));

   p_not_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_NOT) |=> (tos_o == ~$past(tos_o) && $stable(depth_o)));

endmodule

bind stk_tos_core stk_tos_core_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .tos_o    (tos_o),
   .nos_o    (nos_o),
   .depth_o  (depth_o),
   .carry_o  (carry_o),
   .ovf_o    (ovf_o),
   .unf_o    (unf_o),
   .mem_we_o (mem_we_o)
);

// File: tb/stk_tos_core_tb.sv
module stk_tos_core_tb;
   import stk_pkg::*;

   localparam int W     = 16;
   localparam int DEPTH = 256;
   localparam int DW    = 9;
   localparam int NV    = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    op_i = 5'd0;
   logic [W-1:0]  imm_i = '0;
   logic [W-1:0]  mem_rdata_i = '0;
   logic [W-1:0]  page_a_i = 16'hA5A5;
   logic [W-1:0]  page_r_i = 16'h5A0F;
   logic [W-1:0]  rsp_i = 16'h0033;
   logic [W-1:0]  tos_o, nos_o, mem_wdata_o;
   logic [DW-1:0] depth_o;
   logic          carry_o, ovf_o, unf_o, mem_we_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // software model
   logic [15:0] ms [DEPTH];
   int          md;
   logic [15:0] mt;
   logic        mc, mo, mu;

   always #10 clk = ~clk;

   stk_tos_core #(.W(W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i),
      .mem_rdata_i(mem_rdata_i), .page_a_i(page_a_i), .page_r_i(page_r_i),
      .rsp_i(rsp_i), .tos_o(tos_o), .nos_o(nos_o), .depth_o(depth_o),
      .carry_o(carry_o), .ovf_o(ovf_o), .unf_o(unf_o),
      .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o)
   );

   // stimulus table: {op, imm, mem}
   localparam logic [36:0] VEC [NV] = '{
      {5'd1,  16'h1234, 16'h0000},   // LIT
      {5'd1,  16'h00FF, 16'h0000},   // LIT
      {5'd6,  16'h0000, 16'h0000},   // XOR
      {5'd1,  16'hF000, 16'h0000},   // LIT
      {5'd8,  16'h0000, 16'h0000},   // ADD with carry out
      {5'd1,  16'h0010, 16'h0000},   // LIT
      {5'd9,  16'h0000, 16'h0000},   // ADDC
      {5'd10, 16'h0000, 16'h0000},   // SHL
      {5'd11, 16'h0000, 16'h0000},   // SHR
      {5'd11, 16'h0000, 16'h0000},   // SHR
      {5'd5,  16'h0000, 16'h0000},   // NOT
      {5'd2,  16'h0000, 16'h0000},   // DUP
      {5'd1,  16'h0F0F, 16'h0000},   // LIT
      {5'd3,  16'h0000, 16'h0000},   // OVER
      {5'd4,  16'h0000, 16'h0000},   // DROP
      {5'd7,  16'h0000, 16'h0000},   // AND
      {5'd12, 16'h0000, 16'hBEEF},   // LDW
      {5'd13, 16'h0000, 16'hBEEF},   // LDL
      {5'd14, 16'h0000, 16'hC3A7},   // LDH
      {5'd1,  16'h8001, 16'h0000},   // LIT
      {5'd10, 16'h0000, 16'h0000},   // SHL, carry 1
      {5'd15, 16'h0000, 16'h0000},   // RDSR status
      {5'd15, 16'h0001, 16'h0000},   // RDSR page A
      {5'd15, 16'h0002, 16'h0000},   // RDSR page R
      {5'd15, 16'h0003, 16'h0000},   // RDSR depth
      {5'd15, 16'h0004, 16'h0000},   // RDSR rsp
      {5'd15, 16'h0007, 16'h0000},   // RDSR unmapped
      {5'd16, 16'h0000, 16'h0000},   // STW
      {5'd17, 16'h0000, 16'h0000},   // unused opcode
      {5'd9,  16'h0000, 16'h0000}    // ADDC
   };

   function automatic string tag_of(logic [4:0] op);
      case (op)
         5'd1, 5'd2:             return "R2";
         5'd6, 5'd7, 5'd8:       return "R5";
         5'd9:                   return "R6";
         5'd10, 5'd11:           return "R7";
         5'd5:                   return "R8";
         5'd3, 5'd4:             return "R9";
         5'd12, 5'd13, 5'd14:    return "R10";
         5'd15:                  return "R11";
         5'd16:                  return "R12";
         default:                return "R13";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      md = 0; mt = '0; mc = 1'b0; mo = 1'b0; mu = 1'b0;
   endtask

   task automatic check_state(string tag);
      chk(tag, "T", 32'(tos_o), 32'(mt));
      chk(tag, "depth", 32'(depth_o), 32'(md));
      chk(tag, "flags {unf,ovf,carry}", {29'd0, unf_o, ovf_o, carry_o}, {29'd0, mu, mo, mc});
      if (md > 0) chk(tag, "S", 32'(nos_o), 32'(ms[md-1]));
   endtask

   // apply one op at a falling edge, check results at the next falling edge
   task automatic do_op(logic [4:0] op, logic [15:0] imm, logic [15:0] mem);
      bit          push, pop, need_s, fault;
      logic [15:0] s, nt;
      logic [16:0] sum;
      string       tag;
      tag    = tag_of(op);
      push   = (op == 5'd1 || op == 5'd2 || op == 5'd3 || op == 5'd15);
      pop    = (op == 5'd4 || op == 5'd6 || op == 5'd7 || op == 5'd8 || op == 5'd9 || op == 5'd16);
      need_s = pop || op == 5'd3;
      s      = (md > 0) ? ms[md-1] : 16'h0000;
      op_i = op; imm_i = imm; mem_rdata_i = mem;
      #1;
      fault = (need_s && md == 0) || (push && md == DEPTH);
      if (fault) tag = (need_s && md == 0) ? "R4" : "R3";
      chk(tag, "mem_we", 32'(mem_we_o), 32'(op == 5'd16 && !fault));
      if (op == 5'd16 && !fault) chk("R12", "mem_wdata", 32'(mem_wdata_o), 32'(mt));
      if (need_s && md == 0) mu = 1'b1;
      else if (push && md == DEPTH) mo = 1'b1;
      else begin
         nt = mt;
         case (op)
            5'd1:  nt = imm;
            5'd3, 5'd4, 5'd16: nt = s;
            5'd5:  nt = ~mt;
            5'd6:  nt = mt ^ s;
            5'd7:  nt = mt & s;
            5'd8:  begin sum = {1'b0, mt} + {1'b0, s}; nt = sum[15:0]; mc = sum[16]; end
            5'd9:  begin sum = {1'b0, mt} + {1'b0, s} + {16'd0, mc}; nt = sum[15:0]; mc = sum[16]; end
            5'd10: begin mc = mt[15]; nt = {mt[14:0], 1'b0}; end
            5'd11: begin mc = mt[0]; nt = {1'b0, mt[15:1]}; end
            5'd12: nt = mem;
            5'd13: nt = {8'h00, mem[7:0]};
            5'd14: nt = {8'h00, mem[15:8]};
            5'd15: case (imm[2:0])
                      3'd0: nt = {13'd0, mu, mo, mc};
                      3'd1: nt = page_a_i;
                      3'd2: nt = page_r_i;
                      3'd3: nt = 16'(md);
                      3'd4: nt = rsp_i;
                      default: nt = 16'h0000;
                   endcase
            default: nt = mt;
         endcase
         if (push) begin ms[md] = mt; md++; end
         if (pop) md--;
         mt = nt;
      end
      @(negedge clk);
      check_state(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; op_i = 5'd0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");
   endtask

   initial begin
      model_reset();
      do_reset();

      // table walk
      for (int i = 0; i < NV; i++)
         do_op(VEC[i][36:32], VEC[i][31:16], VEC[i][15:0]);

      // underflow on an empty stack (R4)
      do_reset();
      do_op(5'd4,  16'h0, 16'h0);
      do_op(5'd6,  16'h0, 16'h0);
      do_op(5'd16, 16'h0, 16'h0);
      do_op(5'd3,  16'h0, 16'h0);
      do_op(5'd5,  16'h0, 16'h0);      // NOT needs no S
      do_op(5'd15, 16'h0, 16'h0);      // status now shows underflow (R11)
      chk("R11", "status read after underflow", 32'(tos_o), 32'h0000_0004);

      // fill to full, then overflow (R3)
      do_reset();
      for (int i = 0; i < DEPTH; i++) do_op(5'd1, 16'(i * 7 + 3), 16'h0);
      chk("R3", "depth at full", 32'(depth_o), 32'd256);
      do_op(5'd1,  16'hDEAD, 16'h0);
      do_op(5'd2,  16'h0, 16'h0);
      do_op(5'd3,  16'h0, 16'h0);
      do_op(5'd15, 16'h0, 16'h0);
      chk("R3", "overflow sticky", 32'(ovf_o), 32'd1);
      do_op(5'd20, 16'h0, 16'h0);      // unused opcodes (R13)
      do_op(5'd31, 16'h0, 16'h0);
      do_op(5'd0,  16'h0, 16'h0);
      // drain the whole stack, checking every entry
      for (int i = 0; i < DEPTH; i++) do_op(5'd4, 16'h0, 16'h0);
      chk("R4", "empty after drain", 32'(depth_o), 32'd0);
      do_op(5'd4, 16'h0, 16'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule